// File: doc/BRIEF.md
# Optical Motion Sensor Bring-Up Sequencer

This block runs the one-time power-up script of an optical motion sensor. It issues every step as a command to a separate register access engine that owns the serial wires. A command is a register write, a register read, a select assert, a select release, or one raw byte sent while select is held. The script puts the sensor into shutdown, toggles select, issues a power-up reset and reads back the stale motion registers. It then enables the firmware loader and streams a firmware image into the sensor under one held select. The firmware bytes are fetched one by one from an external byte memory. After the upload the block writes the resolution and angle-correction settings, checks three identity registers, and reports the outcome.

The long settling times are counted in clock ticks from parameters: a tick rate per microsecond plus millisecond and microsecond delays. A simulation can shrink them without changing the script. The resolution and angle inputs are sampled when start is accepted and are clamped before they are written.

Top module: `sensor_bringup_seq`

## Requirements
- R1: A one-cycle `start` pulse while idle or finished begins the script and clears `done` and `pass` in the cycle after it is taken. A `start` while the script runs has no effect on the sequence of commands.
- R2: A command is offered with `eng_req` high and is held with stable `eng_op`, `eng_addr` and `eng_wdata` until `eng_ack`. `eng_op` encodes 0 = register write, 1 = register read, 2 = select assert, 3 = select release, 4 = raw byte in `eng_wdata`.
- R3: Commands are issued in this order:
  - write 0xB6 to 0x3B;
  - select assert, then select release;
  - write 0x5A to 0x3A;
  - reads of 0x02, 0x03, 0x04, 0x05 and 0x06;
  - write 0x1D to 0x13, then write 0x18 to 0x13;
  - select assert, then raw byte 0xE2, then the firmware bytes, then select release;
  - read 0x2A, then write 0x00 to 0x10;
  - write the resolution byte to 0x0F, then the angle byte to 0x11;
  - reads of 0x00, 0x3F and 0x2A.
- R4: The gap from the acknowledge of one command to the request of the next is at least the programmed delay:
  - SHUTDOWN_MS after the 0x3B write;
  - CS_US after the select assert and again after the first select release;
  - RESET_MS after the 0x3A write;
  - SROM_MS between the two 0x13 writes;
  - POST_US after the upload's select release;
  - SETTLE_MS after the 0x10 write.
- R5: Firmware bytes are read at addresses 0 to FW_LEN-1 in increasing order. Each read uses a single-cycle `fw_rd_en`, and `fw_data` is taken the cycle after. Each byte is sent as a raw byte unchanged. At least GAP_US separates the 0xE2 byte from the first firmware byte, and each firmware byte from the next command.
- R6: The resolution byte is floor(`cfg_cpi`/100) minus 1, clamped to 0..119. For example, 1600 gives 15, 50 and 100 give 0, and 12000 and 20000 give 119.
- R7: The angle byte is the signed `cfg_angle` clamped to -30..+30 in two's complement. For example, -100 and -30 give 0xE2, 90 gives 0x1E, and 10 gives 0x0A.
- R8: `pass` is high at the end only if the last three reads return 0x42 from 0x00, 0xBD from 0x3F and 0x04 from 0x2A. The earlier read of 0x2A is discarded.
- R9: `done` and `pass` hold their values from the end of the script until the next `start` is taken.
- R10: After reset, `done`, `pass`, `eng_req` and `fw_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begins the script when idle or finished |
| cfg_cpi | input | 16 | Requested resolution in counts per inch |
| cfg_angle | input | 8 | Signed angle correction in degrees |
| eng_req | output | 1 | Command offered to the register access engine |
| eng_op | output | 3 | Command kind |
| eng_addr | output | 7 | Register address for write and read |
| eng_wdata | output | 8 | Write data or raw byte |
| eng_ack | input | 1 | Engine finished the offered command |
| eng_rdata | input | 8 | Read result, valid with `eng_ack` |
| fw_rd_en | output | 1 | Firmware byte read strobe |
| fw_addr | output | FW_AW | Firmware byte address |
| fw_data | input | 8 | Firmware byte, valid one cycle after the strobe |
| done | output | 1 | Script finished |
| pass | output | 1 | Identity check succeeded (valid with `done`) |

## Verification
The hardest behaviour to reach from the ports is the firmware stream. There the block alternates between fetching from the byte memory, offering a raw byte, and timing a gap, all while one select assertion stays open. The stimulus reaches it only by running the whole script against a responder model of the engine and a registered byte memory holding a computed pattern. The bench logs each command with its request and acknowledge cycles. It then compares the log against the expected script, including every streamed byte and every gap bound. A start pulse is also injected during the shutdown wait, to show that the script is not restarted or duplicated.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  typedef enum logic [2:0] {
    OP_WR    = 3'd0,
    OP_RD    = 3'd1,
    OP_SEL   = 3'd2,
    OP_DESEL = 3'd3,
    OP_BYTE  = 3'd4
  } eng_op_e;

  typedef enum logic [2:0] {
    K_ENG    = 3'd0,
    K_CHK    = 3'd1,
    K_WAIT   = 3'd2,
    K_STREAM = 3'd3,
    K_END    = 3'd4
  } step_kind_e;

  typedef enum logic [2:0] {
    W_SHUT   = 3'd0,
    W_CS     = 3'd1,
    W_RST    = 3'd2,
    W_SROM   = 3'd3,
    W_GAP    = 3'd4,
    W_POST   = 3'd5,
    W_SETTLE = 3'd6
  } wait_sel_e;

  typedef struct packed {
    step_kind_e kind;
    eng_op_e    op;
    logic [6:0] addr;
    logic [7:0] data;
    wait_sel_e  wsel;
  } step_t;

  localparam int STEP_W = 5;

  function automatic longint lmax(input longint a, input longint b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bsq_script.sv
module bsq_script
  import bsq_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  input  logic [7:0]        res_byte,
  input  logic [7:0]        ang_byte,
  output step_t             cur
);

  function automatic step_t mk(input step_kind_e k, input eng_op_e o,
                               input logic [6:0] a, input logic [7:0] d,
                               input wait_sel_e w);
    step_t s;
    s.kind = k; s.op = o; s.addr = a; s.data = d; s.wsel = w;
    return s;
  endfunction

  function automatic step_t wr(input logic [6:0] a, input logic [7:0] d);
    return mk(K_ENG, OP_WR, a, d, W_SHUT);
  endfunction

  function automatic step_t rd(input logic [6:0] a);
    return mk(K_ENG, OP_RD, a, 8'h00, W_SHUT);
  endfunction

  function automatic step_t chk(input logic [6:0] a, input logic [7:0] e);
    return mk(K_CHK, OP_RD, a, e, W_SHUT);
  endfunction

  function automatic step_t wt(input wait_sel_e w);
    return mk(K_WAIT, OP_WR, 7'h00, 8'h00, w);
  endfunction

  function automatic step_t ctl(input eng_op_e o, input logic [7:0] d);
    return mk(K_ENG, o, 7'h00, d, W_SHUT);
  endfunction

  always_comb begin
    case (step)
      5'd0:    cur = wr(7'h3B, 8'hB6);
      5'd1:    cur = wt(W_SHUT);
      5'd2:    cur = ctl(OP_SEL, 8'h00);
      5'd3:    cur = wt(W_CS);
      5'd4:    cur = ctl(OP_DESEL, 8'h00);
      5'd5:    cur = wt(W_CS);
      5'd6:    cur = wr(7'h3A, 8'h5A);
      5'd7:    cur = wt(W_RST);
      5'd8:    cur = rd(7'h02);
      5'd9:    cur = rd(7'h03);
      5'd10:   cur = rd(7'h04);
      5'd11:   cur = rd(7'h05);
      5'd12:   cur = rd(7'h06);
      5'd13:   cur = wr(7'h13, 8'h1D);
      5'd14:   cur = wt(W_SROM);
      5'd15:   cur = wr(7'h13, 8'h18);
      5'd16:   cur = ctl(OP_SEL, 8'h00);
      5'd17:   cur = ctl(OP_BYTE, 8'h62 | 8'h80);
      5'd18:   cur = wt(W_GAP);
      5'd19:   cur = mk(K_STREAM, OP_BYTE, 7'h00, 8'h00, W_GAP);
      5'd20:   cur = ctl(OP_DESEL, 8'h00);
      5'd21:   cur = wt(W_POST);
      5'd22:   cur = rd(7'h2A);
      5'd23:   cur = wr(7'h10, 8'h00);
      5'd24:   cur = wt(W_SETTLE);
      5'd25:   cur = wr(7'h0F, res_byte);
      5'd26:   cur = wr(7'h11, ang_byte);
      5'd27:   cur = chk(7'h00, 8'h42);
      5'd28:   cur = chk(7'h3F, 8'hBD);
      5'd29:   cur = chk(7'h2A, 8'h04);
      default: cur = mk(K_END, OP_WR, 7'h00, 8'h00, W_SHUT);
    endcase
  end

endmodule

// File: rtl/bsq_delay.sv
module bsq_delay
  import bsq_pkg::*;
#(
  parameter int TICKS_PER_US = 125,
  parameter int SHUTDOWN_MS  = 300,
  parameter int RESET_MS     = 50,
  parameter int SROM_MS      = 10,
  parameter int SETTLE_MS    = 10,
  parameter int CS_US        = 40,
  parameter int GAP_US       = 15,
  parameter int POST_US      = 200
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  wait_sel_e sel,
  output logic      expired
);

  localparam longint T_SHUT   = longint'(SHUTDOWN_MS) * 1000 * TICKS_PER_US;
  localparam longint T_RST    = longint'(RESET_MS)    * 1000 * TICKS_PER_US;
  localparam longint T_SROM   = longint'(SROM_MS)     * 1000 * TICKS_PER_US;
  localparam longint T_SETTLE = longint'(SETTLE_MS)   * 1000 * TICKS_PER_US;
  localparam longint T_CS     = longint'(CS_US)   * TICKS_PER_US;
  localparam longint T_GAP    = longint'(GAP_US)  * TICKS_PER_US;
  localparam longint T_POST   = longint'(POST_US) * TICKS_PER_US;
  localparam longint T_MAX    = lmax(lmax(lmax(T_SHUT, T_RST), lmax(T_SROM, T_SETTLE)),
                                     lmax(lmax(T_CS, T_GAP), T_POST));
  localparam int     TW       = $clog2(T_MAX + 1);

  logic [TW-1:0] cnt_q, cnt_d, reload;
  logic          cnt_en;

  always_comb begin
    case (sel)
      W_SHUT:   reload = TW'(T_SHUT - 1);
      W_CS:     reload = TW'(T_CS - 1);
      W_RST:    reload = TW'(T_RST - 1);
      W_SROM:   reload = TW'(T_SROM - 1);
      W_GAP:    reload = TW'(T_GAP - 1);
      W_POST:   reload = TW'(T_POST - 1);
      default:  reload = TW'(T_SETTLE - 1);
    endcase
  end

  assign expired = (cnt_q == '0);
  assign cnt_en  = load || !expired;
  assign cnt_d   = load ? reload : (cnt_q - TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/bsq_cfg_clamp.sv
module bsq_cfg_clamp #(
  parameter int RES_MAX = 119,
  parameter int ANG_LIM = 30
) (
  input  logic [15:0]       cpi,
  input  logic signed [7:0] angle,
  output logic [7:0]        res_byte,
  output logic [7:0]        ang_byte
);

  localparam logic signed [7:0] LIM_P = 8'(ANG_LIM);
  localparam logic signed [7:0] LIM_N = -LIM_P;

  logic [15:0] hund;
  assign hund = cpi / 16'd100;

  always_comb begin
    if (hund == 16'd0)                  res_byte = 8'd0;
    else if (hund > 16'(RES_MAX + 1))   res_byte = 8'(RES_MAX);
    else                                res_byte = 8'(hund - 16'd1);
  end

  always_comb begin
    if (angle > LIM_P)      ang_byte = LIM_P;
    else if (angle < LIM_N) ang_byte = LIM_N;
    else                    ang_byte = angle;
  end

endmodule

// File: rtl/sensor_bringup_seq.sv
module sensor_bringup_seq
  import bsq_pkg::*;
#(
  parameter int  FW_LEN       = 4094,
  parameter int  TICKS_PER_US = 125,
  parameter int  SHUTDOWN_MS  = 300,
  parameter int  RESET_MS     = 50,
  parameter int  SROM_MS      = 10,
  parameter int  SETTLE_MS    = 10,
  parameter int  CS_US        = 40,
  parameter int  GAP_US       = 15,
  parameter int  POST_US      = 200,
  localparam int FW_AW        = (FW_LEN > 1) ? $clog2(FW_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       cfg_cpi,
  input  logic signed [7:0] cfg_angle,
  output logic              eng_req,
  output logic [2:0]        eng_op,
  output logic [6:0]        eng_addr,
  output logic [7:0]        eng_wdata,
  input  logic              eng_ack,
  input  logic [7:0]        eng_rdata,
  output logic              fw_rd_en,
  output logic [FW_AW-1:0]  fw_addr,
  input  logic [7:0]        fw_data,
  output logic              done,
  output logic              pass
);

  localparam int IDX_W = $clog2(FW_LEN + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECODE, ST_ENGINE, ST_DELAY, ST_FETCH, ST_CAPTURE, ST_FINISH
  } state_e;

  logic rst_meta_q, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  state_e            state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [7:0]        byte_q, byte_d, res_q, res_d, ang_q, ang_d;
  logic              ok_q, ok_d;
  logic [7:0]        res_c, ang_c;
  logic              tmr_load, tmr_expired;
  wait_sel_e         tmr_sel;
  step_t             cur;

  bsq_cfg_clamp u_clamp (
    .cpi(cfg_cpi), .angle(cfg_angle), .res_byte(res_c), .ang_byte(ang_c)
  );

  bsq_script u_script (
    .step(step_q), .res_byte(res_q), .ang_byte(ang_q), .cur(cur)
  );

  bsq_delay #(
    .TICKS_PER_US(TICKS_PER_US), .SHUTDOWN_MS(SHUTDOWN_MS), .RESET_MS(RESET_MS),
    .SROM_MS(SROM_MS), .SETTLE_MS(SETTLE_MS), .CS_US(CS_US), .GAP_US(GAP_US),
    .POST_US(POST_US)
  ) u_delay (
    .clk(clk), .rst_n(rst_core_n), .load(tmr_load), .sel(tmr_sel), .expired(tmr_expired)
  );

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    idx_d    = idx_q;
    byte_d   = byte_q;
    res_d    = res_q;
    ang_d    = ang_q;
    ok_d     = ok_q;
    tmr_load = 1'b0;
    tmr_sel  = cur.wsel;
    case (state_q)
      ST_IDLE, ST_FINISH: begin
        if (start) begin
          state_d = ST_DECODE;
          step_d  = '0;
          idx_d   = '0;
          ok_d    = 1'b1;
          res_d   = res_c;
          ang_d   = ang_c;
        end
      end
      ST_DECODE: begin
        case (cur.kind)
          K_ENG, K_CHK: state_d = ST_ENGINE;
          K_WAIT: begin
            tmr_load = 1'b1;
            state_d  = ST_DELAY;
          end
          K_STREAM: begin
            if (idx_q == IDX_W'(FW_LEN)) step_d = step_q + STEP_W'(1);
            else                         state_d = ST_FETCH;
          end
          default: state_d = ST_FINISH;
        endcase
      end
      ST_FETCH:   state_d = ST_CAPTURE;
      ST_CAPTURE: begin
        byte_d  = fw_data;
        state_d = ST_ENGINE;
      end
      ST_ENGINE: begin
        if (eng_ack) begin
          if (cur.kind == K_CHK) ok_d = ok_q & (eng_rdata == cur.data);
          if (cur.kind == K_STREAM) begin
            tmr_load = 1'b1;
            tmr_sel  = W_GAP;
            state_d  = ST_DELAY;
          end else begin
            step_d  = step_q + STEP_W'(1);
            state_d = ST_DECODE;
          end
        end
      end
      ST_DELAY: begin
        if (tmr_expired) begin
          if (cur.kind == K_STREAM) idx_d  = idx_q + IDX_W'(1);
          else                      step_d = step_q + STEP_W'(1);
          state_d = ST_DECODE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      idx_q   <= '0;
      byte_q  <= '0;
      res_q   <= '0;
      ang_q   <= '0;
      ok_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      idx_q   <= idx_d;
      byte_q  <= byte_d;
      res_q   <= res_d;
      ang_q   <= ang_d;
      ok_q    <= ok_d;
    end
  end

  assign eng_req   = (state_q == ST_ENGINE);
  assign eng_op    = (cur.kind == K_STREAM) ? OP_BYTE : cur.op;
  assign eng_addr  = cur.addr;
  assign eng_wdata = (cur.kind == K_STREAM) ? byte_q :
                     (cur.kind == K_CHK)    ? 8'h00  : cur.data;
  assign fw_rd_en  = (state_q == ST_FETCH);
  assign fw_addr   = idx_q[FW_AW-1:0];
  assign done      = (state_q == ST_FINISH);
  assign pass      = done & ok_q;

endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
  parameter int FW_LEN = 4094,
  parameter int FW_AW  = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             eng_req,
  input logic [2:0]       eng_op,
  input logic [6:0]       eng_addr,
  input logic [7:0]       eng_wdata,
  input logic             eng_ack,
  input logic             fw_rd_en,
  input logic [FW_AW-1:0] fw_addr,
  input logic             done,
  input logic             pass
);

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && !eng_ack |=> eng_req && $stable(eng_op) && $stable(eng_addr) && $stable(eng_wdata))
    else $error("R2 request dropped or changed before acknowledge");

  a_r5_fetch_single: assert property (@(posedge clk) disable iff (!rst_n)
    fw_rd_en |=> !fw_rd_en && !eng_req)
    else $error("R5 firmware read strobe longer than one cycle");

  a_r5_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    fw_rd_en |-> (int'(fw_addr) < FW_LEN))
    else $error("R5 firmware address out of range");

  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(pass))
    else $error("R9 result changed without start");

  a_r1_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done && start |=> !done && !pass)
    else $error("R1 start did not clear the result");

  a_r1_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req || fw_rd_en |-> !done && !pass)
    else $error("R1 result raised while running");

endmodule

bind sensor_bringup_seq bsq_checker #(.FW_LEN(FW_LEN), .FW_AW(FW_AW)) chk_i (
  .clk(clk), .rst_n(rst_core_n), .start(start), .eng_req(eng_req), .eng_op(eng_op),
  .eng_addr(eng_addr), .eng_wdata(eng_wdata), .eng_ack(eng_ack), .fw_rd_en(fw_rd_en),
  .fw_addr(fw_addr), .done(done), .pass(pass)
);

// File: tb/sensor_bringup_seq_tb_top.sv
module sensor_bringup_seq_tb_top;

  localparam int FWL  = 6;
  localparam int AW   = $clog2(FWL);
  localparam int NTX  = 21 + FWL;
  localparam int T_SHUT = 2000, T_CS = 40, T_RST = 1000, T_SROM = 1000;
  localparam int T_GAP = 15, T_POST = 200, T_SETTLE = 1000;

  logic clk = 1'b0;
  logic rst_n, start;
  logic [15:0] cfg_cpi;
  logic signed [7:0] cfg_angle;
  logic eng_req, eng_ack, fw_rd_en, done, pass;
  logic [2:0] eng_op;
  logic [6:0] eng_addr;
  logic [7:0] eng_wdata, eng_rdata, fw_data;
  logic [AW-1:0] fw_addr;

  int n_chk = 0, n_bad = 0, cyc = 0, n_tx = 0;
  int lg_op [64], lg_addr [64], lg_data [64], lg_req [64], lg_ack [64];
  logic [7:0] id_pid, id_inv, id_rom;
  bit finished = 0;

  always #4 clk = ~clk;

  sensor_bringup_seq #(
    .FW_LEN(FWL), .TICKS_PER_US(1), .SHUTDOWN_MS(2), .RESET_MS(1), .SROM_MS(1),
    .SETTLE_MS(1), .CS_US(40), .GAP_US(15), .POST_US(200)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_cpi(cfg_cpi), .cfg_angle(cfg_angle),
    .eng_req(eng_req), .eng_op(eng_op), .eng_addr(eng_addr), .eng_wdata(eng_wdata),
    .eng_ack(eng_ack), .eng_rdata(eng_rdata), .fw_rd_en(fw_rd_en), .fw_addr(fw_addr),
    .fw_data(fw_data), .done(done), .pass(pass)
  );

  function automatic logic [7:0] fw_pat(input int a);
    return 8'((a * 37 + 8'h5C) & 8'hFF);
  endfunction

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  initial begin
    fw_data = 8'h00;
    forever begin
      @(posedge clk);
      if (fw_rd_en) fw_data <= fw_pat(int'(fw_addr));
    end
  end

  initial begin
    eng_ack = 1'b0;
    eng_rdata = 8'h00;
    forever begin
      @(negedge clk);
      if (eng_req) begin
        if (n_tx < 64) begin
          lg_op[n_tx] = int'(eng_op);
          lg_addr[n_tx] = int'(eng_addr);
          lg_data[n_tx] = int'(eng_wdata);
          lg_req[n_tx] = cyc;
        end
        repeat (2) @(negedge clk);
        case (eng_addr)
          7'h00:   eng_rdata = id_pid;
          7'h3F:   eng_rdata = id_inv;
          7'h2A:   eng_rdata = id_rom;
          default: eng_rdata = 8'h55;
        endcase
        eng_ack = 1'b1;
        if (n_tx < 64) lg_ack[n_tx] = cyc;
        n_tx++;
        @(negedge clk);
        eng_ack = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic exp_at(input int i, input int res_b, input int ang_b,
                        output int op, output int addr, output int data);
    addr = 0; data = 0;
    if (i == 0)               begin op = 0; addr = 'h3B; data = 'hB6; end
    else if (i == 1)          op = 2;
    else if (i == 2)          op = 3;
    else if (i == 3)          begin op = 0; addr = 'h3A; data = 'h5A; end
    else if (i <= 8)          begin op = 1; addr = 2 + (i - 4); end
    else if (i == 9)          begin op = 0; addr = 'h13; data = 'h1D; end
    else if (i == 10)         begin op = 0; addr = 'h13; data = 'h18; end
    else if (i == 11)         op = 2;
    else if (i == 12)         begin op = 4; data = 'hE2; end
    else if (i < 13 + FWL)    begin op = 4; data = int'(fw_pat(i - 13)); end
    else if (i == 13 + FWL)   op = 3;
    else if (i == 14 + FWL)   begin op = 1; addr = 'h2A; end
    else if (i == 15 + FWL)   begin op = 0; addr = 'h10; data = 0; end
    else if (i == 16 + FWL)   begin op = 0; addr = 'h0F; data = res_b; end
    else if (i == 17 + FWL)   begin op = 0; addr = 'h11; data = ang_b; end
    else if (i == 18 + FWL)   begin op = 1; addr = 'h00; end
    else if (i == 19 + FWL)   begin op = 1; addr = 'h3F; end
    else                      begin op = 1; addr = 'h2A; end
  endtask

  task automatic check_log(input int res_b, input int ang_b);
    check(n_tx == NTX, "R3 command count", n_tx, NTX);
    for (int i = 0; i < NTX && i < n_tx; i++) begin
      int op, addr, data;
      bit ok;
      exp_at(i, res_b, ang_b, op, addr, data);
      ok = (lg_op[i] == op);
      if (op <= 1) ok = ok && (lg_addr[i] == addr);
      if (op == 0 || op == 4) ok = ok && (lg_data[i] == data);
      if (i >= 12 && i < 13 + FWL)
        check(ok, "R5 streamed byte", lg_data[i], data);
      else if (i >= 16 + FWL && i <= 17 + FWL)
        check(ok, (i == 16 + FWL) ? "R6 resolution write" : "R7 angle write", lg_data[i], data);
      else
        check(ok, "R3 command", (lg_op[i] << 16) | (lg_addr[i] << 8) | lg_data[i],
              (op << 16) | (addr << 8) | data);
    end
  endtask

  task automatic check_gap(input int i, input int t, input string req);
    int g;
    g = lg_req[i + 1] - lg_ack[i];
    check(g >= t && g <= t + 6, req, g, t);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    int w = 0;
    while (!done && w < 20000) begin
      @(negedge clk);
      w++;
    end
  endtask

  task automatic run_seq(input int cpi, input int ang, input logic [7:0] p,
                         input logic [7:0] v, input logic [7:0] r);
    cfg_cpi = 16'(cpi);
    cfg_angle = 8'(ang);
    id_pid = p; id_inv = v; id_rom = r;
    n_tx = 0;
    pulse_start();
    wait_done();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; cfg_cpi = 16'd0; cfg_angle = 8'sd0;
    id_pid = 8'h42; id_inv = 8'hBD; id_rom = 8'h04;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!done && !pass, "R10 result low after reset", {done, pass}, 0);
    check(!eng_req && !fw_rd_en, "R10 no traffic after reset", {eng_req, fw_rd_en}, 0);
  endtask

  task automatic t_nominal();
    run_seq(1600, 10, 8'h42, 8'hBD, 8'h04);
    check(done && pass, "R8 pass on good identity", {done, pass}, 3);
    check_log(15, 'h0A);
    check_gap(0, T_SHUT, "R4 shutdown wait");
    check_gap(1, T_CS, "R4 select low time");
    check_gap(2, T_CS, "R4 select high time");
    check_gap(3, T_RST, "R4 reset wait");
    check_gap(9, T_SROM, "R4 loader enable wait");
    for (int k = 0; k <= FWL; k++) check_gap(12 + k, T_GAP, "R5 byte gap");
    check_gap(13 + FWL, T_POST, "R4 post upload wait");
    check_gap(15 + FWL, T_SETTLE, "R4 settle wait");
  endtask

  task automatic t_bad_identity();
    run_seq(1200, -100, 8'h42, 8'hBC, 8'h04);
    check(done && !pass, "R8 fail on wrong inverse id", {done, pass}, 2);
    check_log(11, 'hE2);
    run_seq(50, 90, 8'h42, 8'hBD, 8'h03);
    check(done && !pass, "R8 fail on wrong loader id", {done, pass}, 2);
    check_log(0, 'h1E);
  endtask

  task automatic t_clamps();
    run_seq(20000, -30, 8'h42, 8'hBD, 8'h04);
    check(done && pass, "R8 pass", {done, pass}, 3);
    check_log(119, 'hE2);
  endtask

  task automatic t_start_ignored();
    cfg_cpi = 16'd12000; cfg_angle = 8'sd30;
    id_pid = 8'h42; id_inv = 8'hBD; id_rom = 8'h04;
    n_tx = 0;
    pulse_start();
    repeat (100) @(negedge clk);
    check(!done && !pass, "R1 result low while running", {done, pass}, 0);
    cfg_cpi = 16'd100;
    pulse_start();
    wait_done();
    check(done && pass, "R1 run completes despite extra start", {done, pass}, 3);
    check_log(119, 'h1E);
  endtask

  task automatic t_hold_restart();
    logic p0;
    p0 = pass;
    repeat (300) @(negedge clk);
    check(done && pass == p0, "R9 result held", {done, pass}, {1'b1, p0});
    cfg_cpi = 16'd100; cfg_angle = 8'sd0;
    n_tx = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!done && !pass, "R1 start clears result", {done, pass}, 0);
    wait_done();
    check(done && pass, "R8 pass after restart", {done, pass}, 3);
    check_log(0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_nominal();
    t_bad_identity();
    t_clamps();
    t_start_ignored();
    t_hold_restart();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule